// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog counter driven from a word-wide register port. It holds four word registers selected by a 2-bit index: control/status (0), counter (1), timeout (2) and window (3). The counter advances on every clock or on an external slow tick, and when it reaches the programmed timeout it sets a sticky flag and pulses a reset request for one cycle. Software keeps the system alive by writing a refresh key to the counter register.

Configuration is guarded. A key written to the counter register opens a short unlocked interval. In that interval the timeout and window registers may be written, and the control register takes exactly one write. That write closes the interval. An unlocked status bit and a configuration-applied status bit let software poll each step. A control value committed with the update-permit bit cleared locks the configuration until reset.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the control register reads 0x00000420 (applied bit 10 and update-permit bit 5 set), the counter reads 0, the timeout reads TOVAL_RST, the window reads 0 and `rst_req` is low.
- R2: Writing 0xD928C520 to the counter register, or 0x0000C520 followed directly by 0x0000D928, sets the unlocked bit 11 and clears the applied bit 10 one edge later. A wrong second half does not unlock.
- R3: Writes to the timeout and window registers take effect only while the unlocked bit is set.
- R4: The first control write while unlocked captures enable (bit 7), update-permit (bit 5) and tick select (bits 9:8) and clears the unlocked bit. Control writes after that leave the configuration unchanged until the next unlock.
- R5: The applied bit sets exactly RCS_DELAY edges after the committing control write. The new configuration becomes active on that edge and the count restarts at 0.
- R6: If UNLOCK_WIN edges pass after an unlock with no control write, the unlocked bit clears, the configuration stays as it was, and the applied bit returns RCS_DELAY edges later.
- R7: Once a configuration with update-permit 0 is active, unlock keys are ignored until reset.
- R8: A refresh (0x0000A602 followed directly by 0x0000B480, or the word 0xB480A602, to the counter register) sets the count to 0. A wrong second word causes no refresh.
- R9: With enable set, the count advances on every edge when tick select is 0, and only on edges where `tick_lp` is high when tick select is nonzero. With enable clear it holds.
- R10: On the tick that would bring the count to the timeout value, the flag (control bit 14) sets, `rst_req` is high for the following cycle and the count restarts at 0.
- R11: Writing 1 to control bit 14 clears the flag whether or not the block is unlocked. Writing 0 leaves the flag unchanged.
- R12: With a nonzero window, a refresh while the count is below the window value acts as a timeout (flag and `rst_req`). A window of 0 disables this check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_lp | input | 1 | Slow tick enable used when tick select is nonzero |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 2 | Register index: 0 control, 1 counter, 2 timeout, 3 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the indexed register (combinational) |
| wdog_flag | output | 1 | Sticky timeout flag |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
The hardest situation to reach is the update-permit freeze. It needs a full unlock, a committing write with bit 5 cleared and the applied delay. Only after that can a second unlock be shown to do nothing. The stimulus reaches it last, so the earlier phases are not affected. The early-refresh case also needs care, because the refresh must land inside the window a few edges after the configuration is applied. A random phase on the slow tick select mixes refresh words, wrong words and irregular ticks, and checks every edge against a bench model of the count.

// File: rtl/wdog_keyed_pkg.sv
package wdog_keyed_pkg;
   localparam logic [1:0] IDX_CTRL = 2'd0;
   localparam logic [1:0] IDX_CNT  = 2'd1;
   localparam logic [1:0] IDX_TOV  = 2'd2;
   localparam logic [1:0] IDX_WIN  = 2'd3;

   localparam int B_FLAG = 14;
   localparam int B_ULK  = 11;
   localparam int B_RCS  = 10;
   localparam int B_SEL  = 8;
   localparam int B_EN   = 7;
   localparam int B_UPD  = 5;

   localparam logic [15:0] UNL_LO = 16'hC520;
   localparam logic [15:0] UNL_HI = 16'hD928;
   localparam logic [15:0] REF_LO = 16'hA602;
   localparam logic [15:0] REF_HI = 16'hB480;

   typedef struct packed {
      logic       en;
      logic       upd;
      logic [1:0] sel;
   } cfg_t;

   localparam cfg_t CFG_RST = '{en: 1'b0, upd: 1'b1, sel: 2'd0};

   typedef enum logic [1:0] {KS_IDLE, KS_UNL, KS_REF} key_state_e;
endpackage

// File: rtl/wdog_keyseq.sv
module wdog_keyseq
   import wdog_keyed_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cnt_wr,
   input  logic [31:0] wdata,
   output logic        unlock_ev,
   output logic        refresh_ev
);
   key_state_e state_q;
   logic full_unl, full_ref, half_unl, half_ref;

   always_comb begin
      full_unl = (wdata == {UNL_HI, UNL_LO});
      full_ref = (wdata == {REF_HI, REF_LO});
      half_unl = (state_q == KS_UNL) && (wdata == {16'h0, UNL_HI});
      half_ref = (state_q == KS_REF) && (wdata == {16'h0, REF_HI});
      unlock_ev  = cnt_wr && (full_unl || half_unl);
      refresh_ev = cnt_wr && (full_ref || half_ref);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= KS_IDLE;
      end else if (cnt_wr) begin
         if (wdata == {16'h0, UNL_LO})      state_q <= KS_UNL;
         else if (wdata == {16'h0, REF_LO}) state_q <= KS_REF;
         else                               state_q <= KS_IDLE;
      end
   end
endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg
   import wdog_keyed_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int TOVAL_RST  = 1000,
   parameter int RCS_DELAY  = 2,
   parameter int UNLOCK_WIN = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             unlock_ev,
   input  logic             ctrl_wr,
   input  logic             tov_wr,
   input  logic             win_wr,
   input  cfg_t             ctrl_val,
   input  logic [CNT_W-1:0] num_val,
   output logic             ulk,
   output logic             rcs,
   output cfg_t             act,
   output logic [CNT_W-1:0] toval,
   output logic [CNT_W-1:0] window,
   output logic             apply_ev
);
   localparam int WIN_W = $clog2(UNLOCK_WIN + 1);

   logic [WIN_W-1:0] win_cnt;
   logic unlock_ok, win_exp, start_commit;
   cfg_t cfg_next, apply_cfg;

   always_comb begin
      unlock_ok    = unlock_ev && act.upd;
      win_exp      = ulk && (win_cnt == WIN_W'(UNLOCK_WIN - 1));
      start_commit = ulk && !unlock_ok && (ctrl_wr || win_exp);
      cfg_next     = ctrl_wr ? ctrl_val : act;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ulk     <= 1'b0;
         win_cnt <= '0;
         toval   <= CNT_W'(TOVAL_RST);
         window  <= '0;
      end else begin
         if (unlock_ok) begin
            ulk     <= 1'b1;
            win_cnt <= '0;
         end else if (ulk) begin
            if (ctrl_wr || win_exp) ulk <= 1'b0;
            else                    win_cnt <= win_cnt + 1'b1;
            if (tov_wr) toval  <= num_val;
            if (win_wr) window <= num_val;
         end
      end
   end

   generate
      if (RCS_DELAY == 0) begin : g_direct
         assign apply_ev  = start_commit;
         assign apply_cfg = cfg_next;
      end else begin : g_delayed
         localparam int DLY_W = $clog2(RCS_DELAY + 1);
         logic             busy_q;
         logic [DLY_W-1:0] dly_q;
         cfg_t             pend_q;

         assign apply_ev  = busy_q && (dly_q == DLY_W'(RCS_DELAY - 1));
         assign apply_cfg = pend_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               busy_q <= 1'b0;
               dly_q  <= '0;
               pend_q <= CFG_RST;
            end else if (start_commit) begin
               busy_q <= 1'b1;
               dly_q  <= '0;
               pend_q <= cfg_next;
            end else if (unlock_ok || apply_ev) begin
               busy_q <= 1'b0;
            end else if (busy_q) begin
               dly_q <= dly_q + 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act <= CFG_RST;
         rcs <= 1'b1;
      end else begin
         if (apply_ev) act <= apply_cfg;
         if (unlock_ok)     rcs <= 1'b0;
         else if (apply_ev) rcs <= 1'b1;
      end
   end

   if (UNLOCK_WIN < 2) begin : g_chk_win
      $error("wdog_cfg: UNLOCK_WIN must be at least 2");
   end
   if (CNT_W < 31 && TOVAL_RST >= (1 << CNT_W)) begin : g_chk_tov
      $error("wdog_cfg: TOVAL_RST does not fit CNT_W");
   end
endmodule

// File: rtl/wdog_count.sv
module wdog_count
   import wdog_keyed_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_lp,
   input  cfg_t             act,
   input  logic [CNT_W-1:0] toval,
   input  logic [CNT_W-1:0] window,
   input  logic             refresh_ev,
   input  logic             apply_ev,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] count,
   output logic             flag,
   output logic             rst_req
);
   logic             tick, early, hit, fire;
   logic [CNT_W:0]   inc;

   always_comb begin
      tick  = (act.sel == 2'd0) ? 1'b1 : tick_lp;
      inc   = {1'b0, count} + (CNT_W + 1)'(1);
      early = refresh_ev && act.en && (window != '0) && (count < window);
      hit   = act.en && tick && (inc >= {1'b0, toval});
      fire  = !apply_ev && (early || (hit && !refresh_ev));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count   <= '0;
         flag    <= 1'b0;
         rst_req <= 1'b0;
      end else begin
         if (apply_ev || refresh_ev || hit) count <= '0;
         else if (act.en && tick)           count <= inc[CNT_W-1:0];
         if (fire)          flag <= 1'b1;
         else if (flag_clr) flag <= 1'b0;
         rst_req <= fire;
      end
   end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
   import wdog_keyed_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int TOVAL_RST  = 1000,
   parameter int RCS_DELAY  = 2,
   parameter int UNLOCK_WIN = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick_lp,
   input  logic        bus_we,
   input  logic [1:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        wdog_flag,
   output logic        rst_req
);
   logic ctrl_wr, cnt_wr, tov_wr, win_wr;
   logic unlock_ev, refresh_ev, apply_ev;
   logic ulk_q, rcs_q;
   cfg_t act_cfg, ctrl_val;
   logic [CNT_W-1:0] toval_q, window_q, count_q;
   logic [31:0] ctrl_rd;

   always_comb begin
      ctrl_wr  = bus_we && (bus_addr == IDX_CTRL);
      cnt_wr   = bus_we && (bus_addr == IDX_CNT);
      tov_wr   = bus_we && (bus_addr == IDX_TOV);
      win_wr   = bus_we && (bus_addr == IDX_WIN);
      ctrl_val = '{en: bus_wdata[B_EN], upd: bus_wdata[B_UPD],
                   sel: bus_wdata[B_SEL+1:B_SEL]};
   end

   wdog_keyseq keys_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_wr    (cnt_wr),
      .wdata     (bus_wdata),
      .unlock_ev (unlock_ev),
      .refresh_ev(refresh_ev)
   );

   wdog_cfg #(
      .CNT_W     (CNT_W),
      .TOVAL_RST (TOVAL_RST),
      .RCS_DELAY (RCS_DELAY),
      .UNLOCK_WIN(UNLOCK_WIN)
   ) cfg_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .unlock_ev(unlock_ev),
      .ctrl_wr  (ctrl_wr),
      .tov_wr   (tov_wr),
      .win_wr   (win_wr),
      .ctrl_val (ctrl_val),
      .num_val  (bus_wdata[CNT_W-1:0]),
      .ulk      (ulk_q),
      .rcs      (rcs_q),
      .act      (act_cfg),
      .toval    (toval_q),
      .window   (window_q),
      .apply_ev (apply_ev)
   );

   wdog_count #(.CNT_W(CNT_W)) cnt_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_lp   (tick_lp),
      .act       (act_cfg),
      .toval     (toval_q),
      .window    (window_q),
      .refresh_ev(refresh_ev),
      .apply_ev  (apply_ev),
      .flag_clr  (ctrl_wr && bus_wdata[B_FLAG]),
      .count     (count_q),
      .flag      (wdog_flag),
      .rst_req   (rst_req)
   );

   always_comb begin
      ctrl_rd              = '0;
      ctrl_rd[B_FLAG]      = wdog_flag;
      ctrl_rd[B_ULK]       = ulk_q;
      ctrl_rd[B_RCS]       = rcs_q;
      ctrl_rd[B_SEL+1:B_SEL] = act_cfg.sel;
      ctrl_rd[B_EN]        = act_cfg.en;
      ctrl_rd[B_UPD]       = act_cfg.upd;
      case (bus_addr)
         IDX_CTRL: bus_rdata = ctrl_rd;
         IDX_CNT:  bus_rdata = 32'(count_q);
         IDX_TOV:  bus_rdata = 32'(toval_q);
         default:  bus_rdata = 32'(window_q);
      endcase
   end

   if (CNT_W < 1 || CNT_W > 32) begin : g_chk_w
      $error("wdog_keyed: CNT_W must be 1..32");
   end
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_we,
   input logic [1:0]       bus_addr,
   input logic             ulk,
   input logic             rcs,
   input logic             act_en,
   input logic             act_upd,
   input logic             refresh_ev,
   input logic             apply_ev,
   input logic [CNT_W-1:0] count,
   input logic             flag,
   input logic             rst_req
);
   a_r2_ulk_rcs_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(ulk && rcs));

   a_r4_ctrl_write_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 2'd0 && ulk) |=> !ulk);

   a_r5_rcs_after_apply: assert property (@(posedge clk) disable iff (!rst_n)
      apply_ev |=> (rcs || ulk));

   a_r7_frozen_stays_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_upd && !ulk) |=> !ulk);

   a_r8_refresh_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_ev |=> (count == '0));

   a_r9_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_en && !apply_ev && !refresh_ev) |=> $stable(count));

   a_r10_req_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> flag);
endmodule

bind wdog_keyed wdog_keyed_chk #(.CNT_W(CNT_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .ulk       (ulk_q),
   .rcs       (rcs_q),
   .act_en    (act_cfg.en),
   .act_upd   (act_cfg.upd),
   .refresh_ev(refresh_ev),
   .apply_ev  (apply_ev),
   .count     (count_q),
   .flag      (wdog_flag),
   .rst_req   (rst_req)
);

// File: tb/wdog_keyed_tb_top.sv
module wdog_keyed_tb_top;
   localparam int TOV0 = 1000;
   localparam int DLY  = 2;
   localparam int WIN  = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_lp = 1'b0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        wdog_flag, rst_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   wdog_keyed #(.CNT_W(16), .TOVAL_RST(TOV0), .RCS_DELAY(DLY), .UNLOCK_WIN(WIN)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_lp(tick_lp), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .wdog_flag(wdog_flag), .rst_req(rst_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] idx, input logic [31:0] d);
      bus_we = 1'b1; bus_addr = idx; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] idx, output logic [31:0] d);
      bus_addr = idx;
      #1;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic logic [31:0] bit_of(input logic [31:0] v, input int b);
      return {31'd0, v[b]};
   endfunction

   function automatic logic [31:0] next_count(input logic [31:0] c, input logic [31:0] tov);
      return (c + 1 >= tov) ? 32'd0 : c + 1;
   endfunction

   initial begin
      logic [31:0] v;
      int n;
      logic [31:0] mcnt;
      logic mfire;
      void'($urandom(32'd4711));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(0, v); check("R1 ctrl", v, 32'h420);
      rd(1, v); check("R1 count", v, 0);
      rd(2, v); check("R1 toval", v, TOV0);
      rd(3, v); check("R1 window", v, 0);
      check("R1 rst_req", {31'd0, rst_req}, 0);

      // R3 locked timeout write ignored
      wr(2, 32'd50);
      rd(2, v); check("R3 locked toval", v, TOV0);

      // R2 two-half unlock
      wr(1, 32'h0000C520); wr(1, 32'h0000D928);
      rd(0, v); check("R2 ulk set", bit_of(v, 11), 1); check("R2 rcs clear", bit_of(v, 10), 0);

      // R3 writes while unlocked
      wr(2, 32'd20); wr(3, 32'd0);
      rd(2, v); check("R3 unlocked toval", v, 20);

      // R4/R5 commit: en=1 upd=1 sel=0
      wr(0, 32'h000000A0);
      rd(0, v); check("R4 ulk cleared", bit_of(v, 11), 0); check("R5 rcs pending", bit_of(v, 10), 0);
      idle(1);
      rd(0, v); check("R5 rcs one edge", bit_of(v, 10), 0);
      idle(1);
      rd(0, v); check("R5 rcs set", bit_of(v, 10), 1); check("R5 en active", bit_of(v, 7), 1);
      rd(1, v); check("R5 count restart", v, 0);
      idle(5);
      rd(1, v); check("R9 count per edge", v, 5);

      // R4 second control write ignored
      wr(0, 32'h00000020);
      rd(0, v); check("R4 write once", bit_of(v, 7), 1);

      // R8 refresh halves, then wrong second word
      wr(1, 32'h0000A602); wr(1, 32'h0000B480);
      rd(1, v); check("R8 refresh", v, 0);
      wr(1, 32'h0000A602); wr(1, 32'h00001234);
      rd(1, v); check("R8 wrong word", v, 2);

      // R10 timeout
      wr(1, 32'hB480A602);
      n = 0;
      while (n < 100 && !rst_req) begin @(negedge clk); n++; end
      check("R10 timeout cycles", n, 20);
      @(negedge clk);
      check("R10 one-cycle req", {31'd0, rst_req}, 0);
      rd(0, v); check("R10 flag", bit_of(v, 14), 1);
      rd(1, v); check("R10 count restart", v, 1);

      // R11 flag clear
      wr(0, 32'h0);
      rd(0, v); check("R11 write 0 keeps", bit_of(v, 14), 1);
      wr(0, 32'h00004000);
      rd(0, v); check("R11 w1c", bit_of(v, 14), 0);

      // R12 window: early refresh
      wr(1, 32'hD928C520); wr(3, 32'd10); wr(2, 32'd100); wr(0, 32'h000000A0);
      idle(2);
      wr(1, 32'h0000A602); wr(1, 32'h0000B480);
      check("R12 early refresh req", {31'd0, rst_req}, 1);
      rd(0, v); check("R12 early flag", bit_of(v, 14), 1);
      wr(0, 32'h00004000);
      idle(15);
      wr(1, 32'hB480A602);
      check("R12 late refresh no req", {31'd0, rst_req}, 0);
      rd(1, v); check("R12 late refresh count", v, 0);

      // R12 window 0 disables
      wr(1, 32'hD928C520); wr(3, 32'd0); wr(0, 32'h000000A0);
      idle(2);
      wr(1, 32'hB480A602);
      check("R12 window off", {31'd0, rst_req}, 0);

      // R6 unlock window expiry
      wr(1, 32'hD928C520);
      idle(WIN - 1);
      rd(0, v); check("R6 still unlocked", bit_of(v, 11), 1);
      idle(1);
      rd(0, v); check("R6 expired", bit_of(v, 11), 0); check("R6 rcs pending", bit_of(v, 10), 0);
      idle(DLY);
      rd(0, v); check("R6 rcs back", bit_of(v, 10), 1); check("R6 en kept", bit_of(v, 7), 1);
      wr(2, 32'd5);
      rd(2, v); check("R3 after expiry", v, 100);

      // R2 wrong second unlock half
      wr(1, 32'h0000C520); wr(1, 32'h0000D929);
      rd(0, v); check("R2 wrong half", bit_of(v, 11), 0);

      // R9 slow tick select
      wr(1, 32'hD928C520); wr(0, 32'h000001A0);
      idle(2);
      rd(1, v); check("R9 slow start", v, 0);
      idle(10);
      rd(1, v); check("R9 no tick holds", v, 0);
      tick_lp = 1'b1; idle(3); tick_lp = 1'b0;
      rd(1, v); check("R9 three ticks", v, 3);

      // R8/R9/R10 random phase
      mcnt = 3;
      for (int it = 0; it < 400; it++) begin
         int op;
         logic tk;
         op = $urandom % 10;
         tk = 1'($urandom % 2);
         tick_lp = tk;
         if (op == 0) begin
            bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 32'hB480A602;
         end else if (op == 1) begin
            bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h12345678;
         end
         @(negedge clk);
         bus_we = 1'b0;
         if (op == 0) begin
            mcnt = 0; mfire = 1'b0;
         end else if (tk) begin
            mfire = (mcnt + 1 >= 100);
            mcnt = next_count(mcnt, 100);
         end else begin
            mfire = 1'b0;
         end
         rd(1, v); check("R9 random count", v, mcnt);
         check("R10 random req", {31'd0, rst_req}, {31'd0, mfire});
      end
      tick_lp = 1'b0;

      // R7 freeze
      wr(1, 32'hD928C520); wr(0, 32'h00000080);
      idle(2);
      rd(0, v); check("R7 upd cleared", bit_of(v, 5), 0);
      wr(1, 32'hD928C520);
      rd(0, v); check("R7 unlock ignored", bit_of(v, 11), 0);
      wr(2, 32'd7);
      rd(2, v); check("R7 toval kept", v, 100);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule